// File: doc/BRIEF.md
# Scale-Space Extremum Keypoint Detector

This block takes a stream of difference-of-Gaussian samples and flags stable keypoints in it. Each input beat carries one co-registered pixel from every DoG scale of an octave, in raster order. A start-of-frame marker comes with the first pixel of each image. Inside the block, every scale has its own two-row line buffer and 3x3 window register. The scales that have a scale above and below them each drive a test unit. A test unit keeps a candidate only if it passes three checks: it is a strict extremum, its contrast is high enough, and it does not look like an edge.

A keypoint is reported as a one-cycle flag. The flag comes with the centre pixel's column and row, a mask with one bit per middle scale, and the lowest scale index that fired. The block has no back-pressure. A low valid input simply freezes its state until the next sample arrives.

Top module: `sift_kp_detect`

## Requirements
- R1: After reset, until a keypoint is found, `kpFlag` is 0 and `kpMask` is 0.
- R2: Samples arrive one per accepted beat in raster order. `frameStart` marks pixel (0,0). Each report carries the column and row of the window centre in `kpX`/`kpY`.
- R3: A centre value is an extremum only if it is strictly greater than, or strictly less than, all 26 neighbours. The neighbours are the 8 around it in its own scale and the 9 co-located samples in each of the scale below and the scale above.
- R4: A candidate whose absolute centre value is below `contrastThr` is never reported. A value equal to the threshold passes.
- R5: The edge test uses these terms, with C the centre, L/R its row neighbours, U/D its column neighbours and UL/UR/DL/DR the corners: Hxx = L+R-2C, Hyy = U+D-2C, Hxy4 = UL-UR-DL+DR, D16 = 16·Hxx·Hyy − Hxy4². The candidate passes only when D16 > 0 and 160·(Hxx+Hyy)² < 121·D16. This is the curvature-ratio test for ratio 10.
- R6: A centre in column 0, column IMG_W-1, row 0 or row IMG_H-1 is never reported.
- R7: The report for centre (x,y) appears in the cycle after the second rising edge that follows the clock in which sample (x+1,y+1) is accepted.
- R8: Only DoG scales 1 to NUM_SCALES-2 can produce keypoints. Bit i of `kpMask` stands for scale i+1. `kpScale` holds the lowest scale index whose bit is set.
- R9: While `pixValid` is low, no window advances and no report is produced. Idle gaps do not change which keypoints are found, or where.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixValid | input | 1 | A sample beat is present |
| frameStart | input | 1 | The beat is pixel (0,0) of a new image |
| dogIn | input | NUM_SCALES*DATA_W | Signed DoG samples; scale s occupies bits [s*DATA_W +: DATA_W] |
| contrastThr | input | DATA_W | Unsigned minimum absolute centre value |
| kpFlag | output | 1 | Keypoint report strobe |
| kpMask | output | NUM_SCALES-2 | Middle scales that fired at this position |
| kpScale | output | $clog2(NUM_SCALES) | Lowest firing scale index |
| kpX | output | $clog2(IMG_W) | Centre column |
| kpY | output | $clog2(IMG_H) | Centre row |

## Verification
The assertions assume that every image arrives as a complete raster of IMG_W by IMG_H beats. They also assume that `frameStart` is raised only together with `pixValid`, and that `contrastThr` stays steady while an image streams. The stimulus follows these rules: each image is sent whole, starting with a single marked beat, and the threshold changes only between images. Idle gaps are inserted only between beats. Directed images place maxima, minima, a ridge, a weak peak and border peaks at known positions. Random images cover both narrow and full-range sample values.

// File: rtl/sift_kp_pkg.sv
package sift_kp_pkg;
  // strobes from control to datapath for one input beat
  typedef struct packed {
    logic load;   // window shifts by one column
    logic inner;  // window centre lies off the image border
  } kpStrobe_t;
endpackage

// File: rtl/kp_ctrl.sv
module kp_ctrl
  import sift_kp_pkg::*;
#(
  parameter int IMG_W = 12,
  parameter int IMG_H = 10,
  localparam int XW = $clog2(IMG_W),
  localparam int YW = $clog2(IMG_H)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          pixValid,
  input  logic          frameStart,
  output kpStrobe_t     strobe,
  output logic [XW-1:0] wrX,
  output logic [XW-1:0] cenX,
  output logic [YW-1:0] cenY
);
  logic [XW-1:0] nextX, sx;
  logic [YW-1:0] nextY, sy;

  // position of the sample on the bus this cycle
  assign sx = frameStart ? '0 : nextX;
  assign sy = frameStart ? '0 : nextY;

  assign strobe.load  = pixValid;
  assign strobe.inner = pixValid && (sx >= XW'(2)) && (sy >= YW'(2));
  assign wrX  = sx;
  assign cenX = sx - XW'(1);
  assign cenY = sy - YW'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextX <= '0;
      nextY <= '0;
    end else if (pixValid) begin
      if (sx == XW'(IMG_W - 1)) begin
        nextX <= '0;
        nextY <= (sy == YW'(IMG_H - 1)) ? '0 : sy + YW'(1);
      end else begin
        nextX <= sx + XW'(1);
        nextY <= sy;
      end
    end
  end

  assert_pos_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    (nextX < XW'(IMG_W)) && (nextY < YW'(IMG_H)));
endmodule

// File: rtl/kp_scale_test.sv
module kp_scale_test #(
  parameter int DATA_W = 10,
  parameter int EDGE_R = 10,
  localparam int PW = 2 * DATA_W + 14
) (
  input  logic [8:0][DATA_W-1:0] lo,
  input  logic [8:0][DATA_W-1:0] mid,
  input  logic [8:0][DATA_W-1:0] hi,
  input  logic [DATA_W-1:0]      thr,
  output logic                   pass
);
  localparam logic signed [PW-1:0] KNUM = PW'((EDGE_R + 1) * (EDGE_R + 1));
  localparam logic signed [PW-1:0] KDEN = PW'(EDGE_R);

  logic signed [DATA_W-1:0] cen;
  logic signed [DATA_W:0]   cenWide, mag;
  logic                     isMax, isMin, contrastOk, edgeOk;
  logic signed [PW-1:0]     ev [9];
  logic signed [PW-1:0]     hxx, hyy, hxy4, tr, det16;

  assign cen = $signed(mid[4]);

  // strict 26-neighbour comparison
  always_comb begin
    isMax = 1'b1;
    isMin = 1'b1;
    for (int i = 0; i < 9; i++) begin
      if (i != 4) begin
        isMax &= ($signed(mid[i]) < cen);
        isMin &= ($signed(mid[i]) > cen);
      end
      isMax &= ($signed(lo[i]) < cen) && ($signed(hi[i]) < cen);
      isMin &= ($signed(lo[i]) > cen) && ($signed(hi[i]) > cen);
    end
  end

  assign cenWide    = (DATA_W+1)'(cen);
  assign mag        = (cenWide < 0) ? -cenWide : cenWide;
  assign contrastOk = mag >= $signed({1'b0, thr});

  // Hessian terms, off-diagonal kept four times larger to avoid division
  always_comb begin
    for (int i = 0; i < 9; i++) ev[i] = PW'($signed(mid[i]));
  end
  assign hxx   = ev[3] + ev[5] - (ev[4] <<< 1);
  assign hyy   = ev[1] + ev[7] - (ev[4] <<< 1);
  assign hxy4  = ev[0] - ev[2] - ev[6] + ev[8];
  assign tr    = hxx + hyy;
  assign det16 = ((hxx * hyy) <<< 4) - hxy4 * hxy4;
  assign edgeOk = (det16 > 0) && (((KDEN * (tr * tr)) <<< 4) < KNUM * det16);

  assign pass = (isMax || isMin) && contrastOk && edgeOk;

  always_comb begin
    assert_not_both_R3: assert (!(isMax && isMin));
    assert_contrast_R4: assert (!pass || (mag >= $signed({1'b0, thr})));
  end
endmodule

// File: rtl/kp_datapath.sv
module kp_datapath
  import sift_kp_pkg::*;
#(
  parameter int NUM_SCALES = 5,
  parameter int DATA_W = 10,
  parameter int IMG_W = 12,
  parameter int IMG_H = 10,
  parameter int EDGE_R = 10,
  localparam int XW = $clog2(IMG_W),
  localparam int YW = $clog2(IMG_H),
  localparam int NMID = NUM_SCALES - 2,
  localparam int WINB = 9 * DATA_W
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  kpStrobe_t                    strobe,
  input  logic [NUM_SCALES*DATA_W-1:0] dogIn,
  input  logic [XW-1:0]                wrX,
  input  logic [XW-1:0]                cenX,
  input  logic [YW-1:0]                cenY,
  input  logic [DATA_W-1:0]            thr,
  output logic                         kpFlag,
  output logic [NMID-1:0]              kpMask,
  output logic [XW-1:0]                kpX,
  output logic [YW-1:0]                kpY
);
  logic [NUM_SCALES*WINB-1:0] winFlat;
  logic [NMID-1:0]            passVec;
  logic                       loadA, innerA;
  logic [XW-1:0]              xA;
  logic [YW-1:0]              yA;

  for (genvar s = 0; s < NUM_SCALES; s++) begin : g_scale
    logic [DATA_W-1:0]      rowPrev [IMG_W];
    logic [DATA_W-1:0]      rowOld  [IMG_W];
    logic [8:0][DATA_W-1:0] win;
    logic [DATA_W-1:0]      newS;

    assign newS = dogIn[s*DATA_W +: DATA_W];

    always_ff @(posedge clk) begin
      if (strobe.load) begin
        rowOld[wrX]  <= rowPrev[wrX];
        rowPrev[wrX] <= newS;
        win[0] <= win[1];  win[1] <= win[2];  win[2] <= rowOld[wrX];
        win[3] <= win[4];  win[4] <= win[5];  win[5] <= rowPrev[wrX];
        win[6] <= win[7];  win[7] <= win[8];  win[8] <= newS;
      end
    end
    assign winFlat[s*WINB +: WINB] = win;
  end

  for (genvar m = 1; m <= NMID; m++) begin : g_test
    kp_scale_test #(.DATA_W(DATA_W), .EDGE_R(EDGE_R)) u_test (
      .lo  (winFlat[(m-1)*WINB +: WINB]),
      .mid (winFlat[m*WINB +: WINB]),
      .hi  (winFlat[(m+1)*WINB +: WINB]),
      .thr (thr),
      .pass(passVec[m-1])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadA  <= 1'b0;
      innerA <= 1'b0;
      xA     <= '0;
      yA     <= '0;
      kpFlag <= 1'b0;
      kpMask <= '0;
      kpX    <= '0;
      kpY    <= '0;
    end else begin
      loadA  <= strobe.load;
      innerA <= strobe.inner;
      if (strobe.load) begin
        xA <= cenX;
        yA <= cenY;
      end
      kpFlag <= loadA && innerA && (|passVec);
      kpMask <= (loadA && innerA) ? passVec : '0;
      kpX    <= xA;
      kpY    <= yA;
    end
  end

  assert_flag_after_load_R9: assert property (@(posedge clk) disable iff (!rstN)
    kpFlag |-> $past(strobe.load, 2));
  assert_flag_mask_R8: assert property (@(posedge clk) disable iff (!rstN)
    kpFlag |-> (kpMask != '0));
endmodule

// File: rtl/sift_kp_detect.sv
module sift_kp_detect
  import sift_kp_pkg::*;
#(
  parameter int NUM_SCALES = 5,
  parameter int DATA_W = 10,
  parameter int IMG_W = 12,
  parameter int IMG_H = 10,
  parameter int EDGE_R = 10,
  localparam int XW = $clog2(IMG_W),
  localparam int YW = $clog2(IMG_H),
  localparam int NMID = NUM_SCALES - 2,
  localparam int SW = $clog2(NUM_SCALES)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         pixValid,
  input  logic                         frameStart,
  input  logic [NUM_SCALES*DATA_W-1:0] dogIn,
  input  logic [DATA_W-1:0]            contrastThr,
  output logic                         kpFlag,
  output logic [NMID-1:0]              kpMask,
  output logic [SW-1:0]                kpScale,
  output logic [XW-1:0]                kpX,
  output logic [YW-1:0]                kpY
);
  kpStrobe_t     strobe;
  logic [XW-1:0] wrX, cenX;
  logic [YW-1:0] cenY;

  kp_ctrl #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_ctrl (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .frameStart(frameStart),
    .strobe(strobe), .wrX(wrX), .cenX(cenX), .cenY(cenY)
  );

  kp_datapath #(
    .NUM_SCALES(NUM_SCALES), .DATA_W(DATA_W), .IMG_W(IMG_W),
    .IMG_H(IMG_H), .EDGE_R(EDGE_R)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dogIn(dogIn), .wrX(wrX),
    .cenX(cenX), .cenY(cenY), .thr(contrastThr),
    .kpFlag(kpFlag), .kpMask(kpMask), .kpX(kpX), .kpY(kpY)
  );

  // lowest firing scale wins
  always_comb begin
    kpScale = '0;
    for (int i = NMID - 1; i >= 0; i--) begin
      if (kpMask[i]) kpScale = SW'(i + 1);
    end
  end

  assert_border_R6: assert property (@(posedge clk) disable iff (!rstN)
    kpFlag |-> (kpX >= XW'(1)) && (kpX <= XW'(IMG_W - 2)) &&
               (kpY >= YW'(1)) && (kpY <= YW'(IMG_H - 2)));
  assert_scale_sel_R8: assert property (@(posedge clk) disable iff (!rstN)
    kpFlag |-> (kpScale != '0) && kpMask[kpScale - SW'(1)]);
endmodule

// File: tb/sim_sift_kp_detect.sv
module sim_sift_kp_detect;
  localparam int NS = 5;
  localparam int DW = 10;
  localparam int W = 12;
  localparam int H = 10;
  localparam int NMID = NS - 2;
  localparam int CLK_PERIOD = 10;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            pixValid = 1'b0;
  logic            frameStart = 1'b0;
  logic [NS*DW-1:0] dogIn = '0;
  logic [DW-1:0]   contrastThr = '0;
  logic            kpFlag;
  logic [NMID-1:0] kpMask;
  logic [2:0]      kpScale;
  logic [3:0]      kpX, kpY;

  sift_kp_detect #(.NUM_SCALES(NS), .DATA_W(DW), .IMG_W(W), .IMG_H(H), .EDGE_R(10)) u0 (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .frameStart(frameStart),
    .dogIn(dogIn), .contrastThr(contrastThr), .kpFlag(kpFlag), .kpMask(kpMask),
    .kpScale(kpScale), .kpX(kpX), .kpY(kpY)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {int stamp; int x; int y; int m;} expItem_t;
  expItem_t q[$];

  int nChecks = 0;
  int nBad = 0;
  int cyc = 0;
  int thrVal = 0;
  bit running = 1'b0;
  bit done = 1'b0;
  logic [31:0] seed = 32'h1234_5678;
  logic signed [DW-1:0] img [NS][H][W];
  logic [NMID-1:0] seen [H][W];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // reference evaluation from the requirements
  function automatic int refPass(int m, int cx, int cy);
    int c, mag, gt, lt, v;
    longint hxx, hyy, hxy4, tr, d16;
    c = int'(img[m][cy][cx]);
    gt = 1; lt = 1;
    for (int s = m - 1; s <= m + 1; s++)
      for (int dy = -1; dy <= 1; dy++)
        for (int dx = -1; dx <= 1; dx++) begin
          if (!(s == m && dx == 0 && dy == 0)) begin
            v = int'(img[s][cy+dy][cx+dx]);
            if (!(v < c)) gt = 0;
            if (!(v > c)) lt = 0;
          end
        end
    if (gt == 0 && lt == 0) return 0;
    mag = (c < 0) ? -c : c;
    if (mag < thrVal) return 0;
    hxx  = longint'(img[m][cy][cx-1]) + longint'(img[m][cy][cx+1]) - 2 * c;
    hyy  = longint'(img[m][cy-1][cx]) + longint'(img[m][cy+1][cx]) - 2 * c;
    hxy4 = longint'(img[m][cy-1][cx-1]) - longint'(img[m][cy-1][cx+1])
         - longint'(img[m][cy+1][cx-1]) + longint'(img[m][cy+1][cx+1]);
    tr  = hxx + hyy;
    d16 = 16 * hxx * hyy - hxy4 * hxy4;
    if (d16 <= 0) return 0;
    if (!(160 * tr * tr < 121 * d16)) return 0;
    return 1;
  endfunction

  function automatic int refMask(int cx, int cy);
    int m = 0;
    for (int k = 1; k <= NMID; k++) if (refPass(k, cx, cy) != 0) m |= (1 << (k - 1));
    return m;
  endfunction

  function automatic int rnd(int span);
    seed = seed * 32'd1664525 + 32'd1013904223;
    return int'(seed[25:16]) % span - span / 2;
  endfunction

  task automatic clearImg();
    for (int s = 0; s < NS; s++)
      for (int y = 0; y < H; y++)
        for (int x = 0; x < W; x++) img[s][y][x] = '0;
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) seen[y][x] = '0;
  endtask

  // driver: pushes the expected report with the cycle it should be seen in
  task automatic sendFrame(input bit gaps);
    int m;
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) begin
        if (gaps && ((x * 7 + y * 3) % 4 == 0)) begin
          @(negedge clk);
          pixValid = 1'b0;
          frameStart = 1'b0;
        end
        @(negedge clk);
        pixValid = 1'b1;
        frameStart = (x == 0 && y == 0);
        for (int s = 0; s < NS; s++) dogIn[s*DW +: DW] = img[s][y][x];
        if (x >= 2 && y >= 2) begin
          m = refMask(x - 1, y - 1);
          if (m != 0) q.push_back('{cyc + 2, x - 1, y - 1, m});
        end
      end
    @(negedge clk);
    pixValid = 1'b0;
    frameStart = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // monitor: scoreboard comparison
  always @(negedge clk) begin
    if (running) begin
      if (kpFlag) begin
        if (q.size() == 0) begin
          check(1'b0, "R3", "unexpected keypoint at x", int'(kpX), -1);
        end else begin
          expItem_t e;
          int lowest;
          e = q.pop_front();
          lowest = 0;
          for (int k = NMID; k >= 1; k--) if (e.m & (1 << (k - 1))) lowest = k;
          check(cyc == e.stamp, "R7", "report cycle", cyc, e.stamp);
          check(int'(kpX) == e.x && int'(kpY) == e.y, "R2", "coord x*16+y",
                int'(kpX) * 16 + int'(kpY), e.x * 16 + e.y);
          check(int'(kpMask) == e.m, "R3", "scale mask", int'(kpMask), e.m);
          check(int'(kpScale) == lowest, "R8", "scale index", int'(kpScale), lowest);
          seen[kpY][kpX] = seen[kpY][kpX] | kpMask;
        end
      end else if (q.size() != 0 && q[0].stamp == cyc) begin
        check(1'b0, "R7", "missing keypoint mask", 0, q[0].m);
        void'(q.pop_front());
      end
    end
  end

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      nBad++;
      nChecks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(kpFlag == 1'b0, "R1", "flag after reset", int'(kpFlag), 0);
    check(kpMask == '0, "R1", "mask after reset", int'(kpMask), 0);
    running = 1'b1;

    // directed image
    clearImg();
    thrVal = 20;
    contrastThr = DW'(thrVal);
    img[2][4][5] = 10'sd100;                       // maximum, scale 2
    img[1][6][8] = -10'sd80;                       // minimum, scale 1
    for (int y = 2; y <= 6; y++) img[3][y][3] = 10'sd110; // ridge, scale 3
    img[3][4][3] = 10'sd120;
    img[2][2][8] = 10'sd15;                        // weak peak
    img[2][5][0] = 10'sd100;                       // border peaks
    img[2][3][11] = 10'sd100;
    img[2][0][6] = 10'sd100;
    img[2][9][6] = 10'sd100;
    img[0][6][6] = 10'sd100;                       // outer scale peak
    img[4][2][9] = -10'sd100;
    img[1][8][9] = 10'sd100;                       // dual scale hit
    img[2][8][9] = -10'sd100;
    sendFrame(1'b0);
    check(seen[4][5] == 3'b010, "R3", "max at scale 2", int'(seen[4][5]), 2);
    check(seen[6][8] == 3'b001, "R3", "min at scale 1", int'(seen[6][8]), 1);
    check(seen[4][3] == 3'b000, "R5", "ridge rejected", int'(seen[4][3]), 0);
    check(seen[2][8] == 3'b000, "R4", "weak peak rejected", int'(seen[2][8]), 0);
    check(seen[5][0] == 0 && seen[3][11] == 0 && seen[0][6] == 0 && seen[9][6] == 0,
          "R6", "border peaks", 1, 0);
    check(seen[6][6] == 0 && seen[2][9] == 0, "R8", "outer scale peaks", 1, 0);
    check(seen[8][9] == 3'b011, "R8", "dual scale mask", int'(seen[8][9]), 3);

    // threshold equality: the 100 peak passes at threshold 100, fails at 101
    clearImg();
    img[2][4][5] = 10'sd100;
    thrVal = 100;
    contrastThr = DW'(thrVal);
    sendFrame(1'b1);
    check(seen[4][5] == 3'b010, "R4", "centre equal to threshold", int'(seen[4][5]), 2);
    clearImg();
    img[2][4][5] = 10'sd100;
    thrVal = 101;
    contrastThr = DW'(thrVal);
    sendFrame(1'b0);
    check(seen[4][5] == 3'b000, "R4", "centre below threshold", int'(seen[4][5]), 0);

    // random images, narrow and full range, with and without idle gaps (R9)
    for (int f = 0; f < 6; f++) begin
      clearImg();
      for (int s = 0; s < NS; s++)
        for (int y = 0; y < H; y++)
          for (int x = 0; x < W; x++)
            img[s][y][x] = DW'(rnd((f % 2 == 0) ? 128 : 1024));
      thrVal = (f % 3 == 0) ? 0 : 5 * f;
      contrastThr = DW'(thrVal);
      sendFrame(f % 2 == 1);
    end

    check(q.size() == 0, "R9", "pending expected reports", q.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end
endmodule